// File: doc/BRIEF.md
# Phase-Locked 12-to-8 Sample Gearbox

This block turns a stream of wide words, each carrying twelve complex samples and arriving on a slow clock, into a stream of narrower words carrying eight complex samples each on a clock running one and a half times faster. The two clocks share a source, and every third fast rising edge coincides with every second slow rising edge. The domain crossing uses ordinary registers and a modulo-3 word sequencer instead of a dual-clock FIFO, so a given input word always reaches the output after the same number of fast cycles.

The slow side pairs consecutive input words into a 24-sample group. Within a pair, the first slot is taken at the first slow edge after slow reset is released, and the slots then alternate. The fast side finds the pair boundary by watching the slow slot flag, captures each group once, and sends it as three output words. Each output word is gated by a ready input from the consumer. A word offered while ready is low is dropped, and the stream does not stall. The slow reset must be released so that every second-slot slow edge lands on an edge shared by both clocks. That shared edge is where the group register is loaded, and it leaves the fast side a setup window of eight sample periods.

Top module: `sample_gearbox_12to8`

## Requirements
- R1: A complex sample is 32 bits, with I in bits [15:0] and Q in bits [31:16]. Sample n of an input word sits at bits [32n+31:32n], and the same rule holds for output words. For a group made of first word A and second word B, output word j (j = 0, 1, 2) equals bits [256j+255:256j] of the 768-bit value {B, A}.
- R2: Slow slots alternate first, second, first, and so on, starting with the first slot at the first slow edge after rst_slow is released. A group is the first-slot word followed by the next second-slot word. Nothing is emitted before the first group.
- R3: A group counts as valid only if in_valid was high for both of its words. For an invalid group, all three output words come out with out_valid low.
- R4: Output word 0 of a group is registered at the first fast edge after the slow edge that captures the group's second word. Words 1 and 2 follow on the next two fast edges.
- R5: out_valid is high only if out_ready was high at the fast edge that registered the word. A word offered while out_ready is low is dropped, and the words after it keep their timing.
- R6: out_data is all zeros whenever out_valid is low.
- R7: While rst_fast is high, out_valid and out_data are zero at the next fast edge. After release, the first group whose second word is captured after the release is emitted in full.
- R8: With in_valid and out_ready held high, every input sample appears exactly once and in order, as three output words for every two input words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Input-side clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| in_data | input | 384 | Twelve packed complex samples |
| in_valid | input | 1 | Qualifies in_data for this slow cycle |
| clk_fast | input | 1 | Output-side clock, 1.5 times clk_slow, phase-locked |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| out_ready | input | 1 | Consumer accepts the word registered at this edge |
| out_data | output | 256 | Eight packed complex samples |
| out_valid | output | 1 | out_data holds a live word |

## Verification
On the edge shared by both clocks, the slow side loads a new group into the pair register at the same moment the fast side emits the last word of the previous group. That word must come from the fast-side snapshot and not from the pair register, which is changing on that edge. Long runs of back-to-back valid groups with unrelated random data provoke this on every shared edge. Each last word is compared with the upper third of its own group, so a word that leaks in from the following group shows up as a mismatch. A fast reset pulse in the middle of the run then checks that the sequencer locks again on the same boundary.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  // Each captured group drains as this many output words.
  localparam int unsigned NUM_WORDS = 3;

  typedef enum logic [1:0] {
    W_FIRST = 2'd0,
    W_MID   = 2'd1,
    W_LAST  = 2'd2
  } word_idx_t;

  function automatic word_idx_t next_word(input word_idx_t w);
    case (w)
      W_FIRST: return W_MID;
      W_MID:   return W_LAST;
      default: return W_FIRST;
    endcase
  endfunction

endpackage

// File: rtl/gbx_slow_pair.sv
module gbx_slow_pair #(
  parameter int unsigned WORD_W = 384
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     in_data,
  input  logic                  in_valid,
  output logic                  slot,
  output logic [2*WORD_W-1:0]   pair_data,
  output logic                  pair_valid
);

  logic [WORD_W-1:0] first_q;
  logic              first_v_q;

  // Control: slot flag and qualifiers carry the reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot       <= 1'b0;
      first_v_q  <= 1'b0;
      pair_valid <= 1'b0;
    end else begin
      slot <= ~slot;
      if (!slot) begin
        first_v_q <= in_valid;
      end else begin
        pair_valid <= first_v_q & in_valid;
      end
    end
  end

  // Data path kept free of reset so it maps onto plain flop banks.
  always_ff @(posedge clk) begin
    if (!slot) begin
      first_q <= in_data;
    end else begin
      pair_data <= {in_data, first_q};
    end
  end

  p_slot_rise_r2: assert property (@(posedge clk) disable iff (rst)
    !slot |=> slot);

  p_slot_fall_r2: assert property (@(posedge clk) disable iff (rst)
    slot |=> !slot);

  p_pair_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !slot |=> $stable(pair_valid));

  p_pair_both_r3: assert property (@(posedge clk) disable iff (rst)
    (slot && !in_valid) |=> !pair_valid);

endmodule

// File: rtl/gbx_phase_seq.sv
module gbx_phase_seq
  import gbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      slot_in,
  output logic      cap,
  output logic      live,
  output word_idx_t idx
);

  logic      seen_q;
  logic      locked_q;
  word_idx_t ph_q;
  logic      edge_hit;

  // The slot flag falls on the shared edge where the group is loaded.
  // The first fast edge that sees it low, after it was seen high, is the
  // capture edge.
  assign edge_hit = seen_q & ~slot_in;
  assign cap      = locked_q ? (ph_q == W_FIRST) : edge_hit;
  assign live     = locked_q | edge_hit;
  assign idx      = cap ? W_FIRST : ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      ph_q     <= W_FIRST;
    end else begin
      seen_q <= slot_in;
      if (cap) begin
        locked_q <= 1'b1;
        ph_q     <= W_MID;
      end else if (locked_q) begin
        ph_q <= next_word(ph_q);
      end
    end
  end

  p_lock_on_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    (locked_q && ph_q == W_FIRST) |-> edge_hit);

  p_no_stray_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    (locked_q && ph_q != W_FIRST) |-> !edge_hit);

  p_cap_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cap);

endmodule

// File: rtl/gbx_word_out.sv
module gbx_word_out
  import gbx_pkg::*;
#(
  parameter int unsigned OUT_W   = 256,
  parameter int unsigned GROUP_W = 768
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] pair_data,
  input  logic               pair_valid,
  input  logic               cap,
  input  logic               live,
  input  word_idx_t          idx,
  input  logic               ready,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_valid
);

  localparam int unsigned SNAP_W = GROUP_W - OUT_W;

  logic [SNAP_W-1:0] snap_q;
  logic              grp_v_q;
  logic [OUT_W-1:0]  words [NUM_WORDS];
  logic [OUT_W-1:0]  sel_word;
  logic              emit_v;

  // Word 0 is read straight from the pair register on the capture edge.
  // Later words come from the snapshot, which stays clear of the next load.
  for (genvar j = 0; j < NUM_WORDS; j++) begin : g_word
    if (j == 0) begin : g_direct
      assign words[j] = pair_data[OUT_W-1:0];
    end else begin : g_snap
      assign words[j] = snap_q[(j-1)*OUT_W +: OUT_W];
    end
  end

  always_comb begin
    sel_word = '0;
    for (int j = 0; j < NUM_WORDS; j++) begin
      if (idx == word_idx_t'(j)) sel_word = words[j];
    end
  end

  assign emit_v = live & ready & (cap ? pair_valid : grp_v_q);

  always_ff @(posedge clk) begin
    if (cap) snap_q <= pair_data[GROUP_W-1:OUT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_v_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (cap) grp_v_q <= pair_valid;
      out_valid <= emit_v;
      out_data  <= emit_v ? sel_word : '0;
    end
  end

  p_valid_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ready));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0));

  p_bad_group_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (cap && !pair_valid) |=> !out_valid);

endmodule

// File: rtl/sample_gearbox_12to8.sv
module sample_gearbox_12to8
  import gbx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 16,
  parameter int unsigned IN_SAMPLES  = 12,
  parameter int unsigned OUT_SAMPLES = 8
) (
  input  logic                                clk_slow,
  input  logic                                rst_slow,
  input  logic [IN_SAMPLES*2*SAMPLE_W-1:0]    in_data,
  input  logic                                in_valid,
  input  logic                                clk_fast,
  input  logic                                rst_fast,
  input  logic                                out_ready,
  output logic [OUT_SAMPLES*2*SAMPLE_W-1:0]   out_data,
  output logic                                out_valid
);

  // Two input words must equal NUM_WORDS output words.
  localparam int unsigned CPLX_W  = 2 * SAMPLE_W;
  localparam int unsigned IN_W    = IN_SAMPLES * CPLX_W;
  localparam int unsigned OUT_W   = OUT_SAMPLES * CPLX_W;
  localparam int unsigned GROUP_W = 2 * IN_W;

  logic               s_slot;
  logic [GROUP_W-1:0] s_pair_data;
  logic               s_pair_valid;
  logic               f_cap;
  logic               f_live;
  word_idx_t          f_idx;

  gbx_slow_pair #(.WORD_W(IN_W)) u_pair (
    .clk        (clk_slow),
    .rst        (rst_slow),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .slot       (s_slot),
    .pair_data  (s_pair_data),
    .pair_valid (s_pair_valid)
  );

  gbx_phase_seq u_seq (
    .clk     (clk_fast),
    .rst     (rst_fast),
    .slot_in (s_slot),
    .cap     (f_cap),
    .live    (f_live),
    .idx     (f_idx)
  );

  gbx_word_out #(.OUT_W(OUT_W), .GROUP_W(GROUP_W)) u_out (
    .clk        (clk_fast),
    .rst        (rst_fast),
    .pair_data  (s_pair_data),
    .pair_valid (s_pair_valid),
    .cap        (f_cap),
    .live       (f_live),
    .idx        (f_idx),
    .ready      (out_ready),
    .out_data   (out_data),
    .out_valid  (out_valid)
  );

endmodule

// File: tb/sample_gearbox_12to8_test.sv
`timescale 1ns/1ps
module sample_gearbox_12to8_test;

  localparam int NF   = 300;  // frames of 12 ns, one group each
  localparam int CONT = 40;   // leading frames with valid and ready held high
  localparam int FA   = 150;  // fast reset asserted in this frame
  localparam int FB   = 153;  // and released in this frame

  logic         clk_fast = 1'b0;
  logic         clk_slow = 1'b0;
  logic         rst_fast = 1'b1;
  logic         rst_slow = 1'b1;
  logic [383:0] in_data  = '0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [255:0] out_data;
  logic         out_valid;

  int tick  = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [383:0] lo_d [0:NF];
  logic [383:0] hi_d [0:NF];
  bit           lo_v [0:NF];
  bit           hi_v [0:NF];
  logic [2:0]   rdy  [0:NF];

  sample_gearbox_12to8 uut (
    .clk_slow  (clk_slow),
    .rst_slow  (rst_slow),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .clk_fast  (clk_fast),
    .rst_fast  (rst_fast),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  // One process makes both clocks: fast 4 ns (250 MHz), slow 6 ns, rising together every 12 ns.
  initial begin
    forever begin
      clk_fast = (tick % 4) < 2;
      clk_slow = (tick % 6) < 3;
      #1;
      tick++;
    end
  end

  function automatic logic [383:0] rnd_word();
    logic [383:0] w;
    for (int i = 0; i < 12; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  function automatic logic [255:0] exp_word(int k, int j);
    logic [767:0] g;
    g = {hi_d[k], lo_d[k]};
    return g[j*256 +: 256];
  endfunction

  task automatic compare(string vtag, string dtag, int k, int j,
                         logic ev, logic [255:0] ed);
    n_chk++;
    if (out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s group %0d word %0d: out_valid got %0b exp %0b",
               vtag, k, j, out_valid, ev);
    end
    n_chk++;
    if (out_data !== ed) begin
      n_bad++;
      $display("FAIL %s group %0d word %0d: out_data got %h exp %h",
               dtag, k, j, out_data, ed);
    end
  endtask

  task automatic check_word(int k, int j);
    bit    grp;
    bit    inrst;
    logic  ev;
    string vtag;
    grp   = lo_v[k] && hi_v[k];
    inrst = (k >= FA) && (k <= FB);
    ev    = grp && rdy[k][j] && !inrst;
    if (inrst)             vtag = "R7";
    else if (!grp)         vtag = "R3";
    else if (!rdy[k][j])   vtag = "R5";
    else if (k == 0)       vtag = "R2";
    else if (k < CONT)     vtag = "R8";
    else                   vtag = "R4";
    compare(vtag, ev ? "R1" : "R6", k, j, ev, ev ? exp_word(k, j) : 256'd0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog: run got no end, exp end before 100000 ns");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k <= NF; k++) begin
      lo_d[k] = rnd_word();
      hi_d[k] = rnd_word();
      if (k < CONT) begin
        lo_v[k] = 1'b1;
        hi_v[k] = 1'b1;
        rdy[k]  = 3'b111;
      end else begin
        lo_v[k] = ($urandom % 10) != 0;
        hi_v[k] = ($urandom % 10) != 0;
        for (int j = 0; j < 3; j++) rdy[k][j] = ($urandom % 5) != 0;
      end
    end
    // Directed corners.
    lo_v[50] = 1'b0; hi_v[50] = 1'b1; rdy[50] = 3'b111;  // R3 first word missing
    lo_v[51] = 1'b1; hi_v[51] = 1'b0; rdy[51] = 3'b111;  // R3 second word missing
    lo_v[52] = 1'b1; hi_v[52] = 1'b1; rdy[52] = 3'b000;  // R5 all words refused
    lo_v[53] = 1'b1; hi_v[53] = 1'b1; rdy[53] = 3'b010;  // R5 only middle word taken
    lo_v[FA-1] = 1'b1; hi_v[FA-1] = 1'b1; rdy[FA-1] = 3'b111;
    lo_v[FB+1] = 1'b1; hi_v[FB+1] = 1'b1; rdy[FB+1] = 3'b111;  // R7 resumes here

    // R7: reset state.
    #20;
    compare("R7", "R7", -1, 0, 1'b0, 256'd0);

    // t = 25: leave reset just after the shared edge at 24; drive group 0 first word.
    #5;
    rst_slow = 1'b0;
    rst_fast = 1'b0;
    in_data  = lo_d[0];
    in_valid = lo_v[0];
    #6;  // t = 31: group 0 second word, captured at 36
    in_data  = hi_d[0];
    in_valid = hi_v[0];
    #5;  // t = 36, start of frame 0

    for (int k = 0; k <= NF; k++) begin
      #1;  // T+1
      if (k == FA) rst_fast = 1'b1;
      if (k == FB) rst_fast = 1'b0;
      if (k < NF) begin
        in_data  = lo_d[k+1];
        in_valid = lo_v[k+1];
        out_ready = rdy[k][0];
      end else begin
        in_valid  = 1'b0;
        out_ready = 1'b0;
      end
      #2;  // T+3: last word of the previous group
      if (k == 0) compare("R2", "R6", -1, 2, 1'b0, 256'd0);
      else        check_word(k-1, 2);
      if (k == NF) break;
      #2;  // T+5: first word of this group
      check_word(k, 0);
      #2;  // T+7
      in_data   = hi_d[k+1];
      in_valid  = hi_v[k+1];
      out_ready = rdy[k][1];
      #3;  // T+10: middle word
      check_word(k, 1);
      out_ready = rdy[k][2];
      #2;  // next frame
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule